// File: doc/BRIEF.md
# Banked Save-RAM Bus Mapper

This block sits on a 24-bit CPU bus. It turns each access into a region kind and, for battery-backed save RAM, into an offset inside a byte-wide array. A table of regions, indexed by the bank byte of the address, gives every 64 KiB block a kind and an access-cost value. Software loads the table and a save-RAM size mask through two configuration ports while the bus is idle.

Save RAM can be reached through two address translations. The first folds the bank byte into the offset. The second places a window at 0x6000 in each bank and adds bank bits. Both translations are cut down by the runtime size mask. A second work RAM uses its window offset with no mask. Reads of unmapped or CPU-register blocks return a retained open-bus byte. A 16-bit access runs as two byte beats, low byte first. Each beat is translated on its own, so under a small mask the high byte can land far from the low byte. Every access reports its cycle cost on a pulsed output, for the CPU-side timing model.

Top module: `sram_bus_mapper`

## Requirements
- R1: Reset sets every region-table entry to kind 0 (unmapped) with cost 0. A configuration write loads the kind and cost for the block selected by address bits 23:16. Kind codes: 0 unmapped, 1 CPU registers, 2 bank-fold save RAM, 3 window save RAM, 4 work RAM.
- R2: In a kind-2 block, the save-RAM offset is {addr[23:16], addr[14:0]} ANDed with the size mask.
- R3: In a kind-3 block, the save-RAM offset is (addr[14:0] - 0x6000 + (addr[19:16] << 13)) ANDed with the size mask. Both save-RAM kinds share one array.
- R4: In a kind-4 block, the work-RAM offset is addr[14:0] - 0x6000 with no mask applied. Work-RAM writes are never gated.
- R5: A save-RAM write is discarded while the size mask is zero.
- R6: The modified flag is 0 after reset. It is set by every accepted save-RAM or work-RAM write, and it stays set until reset.
- R7: A byte read from a kind-0 or kind-1 block returns the open-bus byte. That byte is 0 after reset and takes the value of every byte read from either RAM. A 16-bit read of such a block returns the byte in both halves.
- R8: A 16-bit access is a low-byte beat at the address followed by a high-byte beat at address+1. Each beat is translated separately.
- R9: When address bits 11:0 are all ones, each beat of a 16-bit access does its own table lookup and reports its own cost. The first byte read reaches the open-bus byte before the second beat's data is chosen.
- R10: The cost pulse carries the block's cost for a byte beat and twice that value for an unsplit 16-bit access. The pulse comes once per access, or once per beat when the access is split. The cost is 0 for a kind-1 block accessed with the DMA flag set.
- R11: Read data is valid one cycle after a byte request is accepted and two cycles after a 16-bit request is accepted. Busy is high for exactly the one cycle of the high beat, and requests raised while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Region-table write strobe |
| cfg_idx | input | BLK_BITS | Block index to load |
| cfg_kind | input | 3 | Region kind code |
| cfg_speed | input | SPD_W | Access cost for the block |
| mask_we | input | 1 | Size-mask write strobe |
| mask_val | input | SRAM_AW | New save-RAM size mask |
| req | input | 1 | Access request |
| req_we | input | 1 | 1 for write, 0 for read |
| req_wide | input | 1 | 1 for a 16-bit access |
| req_dma | input | 1 | Access made by DMA |
| req_addr | input | 24 | CPU bus address |
| req_wdata | input | 16 | Write data, low byte in bits 7:0 |
| busy | output | 1 | High beat in progress; requests ignored |
| rvalid | output | 1 | Read data valid |
| rdata | output | 16 | Read data; upper byte 0 for byte reads |
| cost_vld | output | 1 | Cost pulse |
| cost | output | SPD_W+1 | Cost value carried by the pulse |
| sram_dirty | output | 1 | Sticky save-RAM modified flag |

## Verification
Writes through one address are read back through other addresses that the formulas map to the same offset. Bank-fold aliases show that bank bits above the mask drop out. Window addresses in different banks show the bank term, and pairing a window address with a fold address shows that both kinds share one array. Zero, small and full masks separate correct gating and per-byte translation from a design that reuses the low offset for the high byte. Split accesses at the 12-bit boundary, including one that crosses into an unmapped bank, separate per-beat lookup and open-bus ordering from one combined access.

// File: rtl/sram_bus_mapper.sv
`timescale 1ns/1ps
module sram_bus_mapper #(
  parameter int BLK_BITS = 8,
  parameter int SPD_W    = 4,
  parameter int SRAM_AW  = 10,
  parameter int WRAM_AW  = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [BLK_BITS-1:0] cfg_idx,
  input  logic [2:0]          cfg_kind,
  input  logic [SPD_W-1:0]    cfg_speed,
  input  logic                mask_we,
  input  logic [SRAM_AW-1:0]  mask_val,
  input  logic                req,
  input  logic                req_we,
  input  logic                req_wide,
  input  logic                req_dma,
  input  logic [23:0]         req_addr,
  input  logic [15:0]         req_wdata,
  output logic                busy,
  output logic                rvalid,
  output logic [15:0]         rdata,
  output logic                cost_vld,
  output logic [SPD_W:0]      cost,
  output logic                sram_dirty
);
  localparam int NBLK   = 1 << BLK_BITS;
  localparam int SRAM_N = 1 << SRAM_AW;
  localparam int WRAM_N = 1 << WRAM_AW;
  localparam logic [2:0] K_NONE = 3'd0, K_CPU = 3'd1, K_FOLD = 3'd2, K_WIN = 3'd3, K_WORK = 3'd4;
  localparam logic [1:0] S_OB = 2'd0, S_SRAM = 2'd1, S_WORK = 2'd2;

  logic [2:0]         kind_tbl [NBLK];
  logic [SPD_W-1:0]   spd_tbl  [NBLK];
  logic [SRAM_AW-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NBLK; i++) begin
        kind_tbl[i] <= K_NONE;
        spd_tbl[i]  <= '0;
      end
      mask_q <= '0;
    end else begin
      if (cfg_we) begin
        kind_tbl[cfg_idx] <= cfg_kind;
        spd_tbl[cfg_idx]  <= cfg_speed;
      end
      if (mask_we) mask_q <= mask_val;
    end

  logic        b1_pend, b1_we, b1_dma, b1_split;
  logic [23:0] b1_addr;
  logic [7:0]  b1_wd;

  wire go       = req & ~b1_pend;
  wire act      = go | b1_pend;
  wire split_rq = &req_addr[11:0];

  wire [23:0] cur_addr = b1_pend ? b1_addr : req_addr;
  wire        cur_we   = b1_pend ? b1_we   : req_we;
  wire        cur_dma  = b1_pend ? b1_dma  : req_dma;
  wire [7:0]  cur_wd   = b1_pend ? b1_wd   : req_wdata[7:0];

  wire [BLK_BITS-1:0] cur_blk  = cur_addr[23 -: BLK_BITS];
  wire [2:0]          cur_kind = kind_tbl[cur_blk];
  wire [SPD_W-1:0]    cur_spd  = spd_tbl[cur_blk];

  wire [22:0] fold_raw = {cur_addr[23:16], cur_addr[14:0]};
  wire [19:0] win_raw  = {5'd0, cur_addr[14:0]} - 20'h06000 + {3'd0, cur_addr[19:16], 13'd0};
  wire [14:0] work_raw = cur_addr[14:0] - 15'h6000;

  wire [SRAM_AW-1:0] sram_off = (cur_kind == K_FOLD) ? (fold_raw[SRAM_AW-1:0] & mask_q)
                                                     : (win_raw[SRAM_AW-1:0] & mask_q);
  wire [WRAM_AW-1:0] work_off = work_raw[WRAM_AW-1:0];

  wire sram_sel = act & ((cur_kind == K_FOLD) | (cur_kind == K_WIN));
  wire work_sel = act & (cur_kind == K_WORK);
  wire sram_wr  = sram_sel & cur_we & (|mask_q);
  wire work_wr  = work_sel & cur_we;

  wire unused_ok = ^{cur_addr, fold_raw, win_raw, work_raw};

  logic [7:0] sram_mem [SRAM_N];
  logic [7:0] work_mem [WRAM_N];
  logic [7:0] sram_q, work_q;

  always_ff @(posedge clk) begin
    if (sram_wr) sram_mem[sram_off] <= cur_wd;
    sram_q <= sram_mem[sram_off];
    if (work_wr) work_mem[work_off] <= cur_wd;
    work_q <= work_mem[work_off];
  end

  logic       rd_pend, rd_last, rd_wide;
  logic [1:0] rd_src;
  logic [7:0] lo_q, ob_q;

  wire [7:0] byte_now = (rd_src == S_SRAM) ? sram_q :
                        (rd_src == S_WORK) ? work_q : ob_q;

  wire             free_beat = (cur_kind == K_CPU) & cur_dma;
  wire [SPD_W-1:0] base      = free_beat ? '0 : cur_spd;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      b1_pend <= 1'b0; b1_we <= 1'b0; b1_dma <= 1'b0; b1_split <= 1'b0;
      b1_addr <= '0;   b1_wd <= '0;
      rd_pend <= 1'b0; rd_last <= 1'b0; rd_wide <= 1'b0; rd_src <= S_OB;
      lo_q <= '0; ob_q <= '0;
      cost_vld <= 1'b0; cost <= '0;
      sram_dirty <= 1'b0;
    end else begin
      if (go & req_wide) begin
        b1_pend  <= 1'b1;
        b1_addr  <= req_addr + 24'd1;
        b1_we    <= req_we;
        b1_dma   <= req_dma;
        b1_split <= split_rq;
        b1_wd    <= req_wdata[15:8];
      end else begin
        b1_pend <= 1'b0;
      end

      rd_pend <= act & ~cur_we;
      rd_last <= b1_pend | ~req_wide;
      rd_wide <= b1_pend | req_wide;
      rd_src  <= sram_sel ? S_SRAM : (work_sel ? S_WORK : S_OB);
      if (rd_pend & (rd_src != S_OB)) ob_q <= byte_now;
      if (rd_pend & ~rd_last) lo_q <= byte_now;

      cost_vld <= go | (b1_pend & b1_split);
      cost     <= (go & req_wide & ~split_rq) ? {base, 1'b0} : {1'b0, base};

      if (sram_wr | work_wr) sram_dirty <= 1'b1;
    end

  assign busy   = b1_pend;
  assign rvalid = rd_pend & rd_last;
  assign rdata  = rd_wide ? {byte_now, lo_q} : {8'h00, byte_now};

  p_high_beat_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
  p_wide_sets_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req & !busy & req_wide) |=> busy);
  p_byte_read_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req & !busy & !req_we & !req_wide) |=> rvalid);
  p_zero_mask_no_dirty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_sel & cur_we & (mask_q == '0) & !work_sel) |=> $stable(sram_dirty));
  p_dirty_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dirty |=> sram_dirty);
  p_dma_cpu_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req & !busy & req_dma & (cur_kind == K_CPU)) |=> (cost_vld && cost == '0));
endmodule

// File: tb/tb_sram_bus_mapper.sv
`timescale 1ns/1ps
module tb_sram_bus_mapper;
  localparam int AW = 14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, mask_we = 0, req = 0, req_we = 0, req_wide = 0, req_dma = 0;
  logic [7:0] cfg_idx = '0;
  logic [2:0] cfg_kind = '0;
  logic [3:0] cfg_speed = '0;
  logic [AW-1:0] mask_val = '0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic busy, rvalid, cost_vld, sram_dirty;
  logic [15:0] rdata;
  logic [4:0] cost;

  sram_bus_mapper #(.BLK_BITS(8), .SPD_W(4), .SRAM_AW(AW), .WRAM_AW(10)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_kind(cfg_kind),
    .cfg_speed(cfg_speed), .mask_we(mask_we), .mask_val(mask_val), .req(req),
    .req_we(req_we), .req_wide(req_wide), .req_dma(req_dma), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .rvalid(rvalid), .rdata(rdata),
    .cost_vld(cost_vld), .cost(cost), .sram_dirty(sram_dirty));

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit done = 0;

  // {we, wide, addr, wdata, expected read data}
  localparam logic [57:0] VEC [14] = '{
    {1'b1, 1'b0, 24'h700005, 16'h00A5, 16'h0000},
    {1'b0, 1'b0, 24'h714005, 16'h0000, 16'h00A5},
    {1'b1, 1'b0, 24'h206010, 16'h003C, 16'h0000},
    {1'b0, 1'b0, 24'h700010, 16'h0000, 16'h003C},
    {1'b1, 1'b0, 24'h216010, 16'h005A, 16'h0000},
    {1'b0, 1'b0, 24'h702010, 16'h0000, 16'h005A},
    {1'b0, 1'b0, 24'h226010, 16'h0000, 16'h003C},
    {1'b1, 1'b1, 24'h700020, 16'hBEEF, 16'h0000},
    {1'b0, 1'b1, 24'h700020, 16'h0000, 16'hBEEF},
    {1'b0, 1'b0, 24'h206021, 16'h0000, 16'h00BE},
    {1'b1, 1'b0, 24'h406003, 16'h0077, 16'h0000},
    {1'b0, 1'b0, 24'h40E003, 16'h0000, 16'h0077},
    {1'b1, 1'b1, 24'h406100, 16'h1234, 16'h0000},
    {1'b0, 1'b0, 24'h406101, 16'h0000, 16'h0012}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [7:0] idx, input logic [2:0] k, input logic [3:0] s);
    @(negedge clk); cfg_we = 1; cfg_idx = idx; cfg_kind = k; cfg_speed = s;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic setmask(input logic [AW-1:0] m);
    @(negedge clk); mask_we = 1; mask_val = m;
    @(negedge clk); mask_we = 0;
  endtask

  task automatic access(input logic we, input logic wide, input logic dma,
                        input logic [23:0] a, input logic [15:0] wd,
                        output logic [15:0] rd, output int nc, output int cs, output int rvat);
    @(negedge clk);
    req = 1; req_we = we; req_wide = wide; req_dma = dma; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req = 0;
    nc = 0; cs = 0; rvat = -1; rd = '0;
    for (int k = 0; k < 3; k++) begin
      if (cost_vld) begin nc++; cs += int'(cost); end
      if (rvalid && rvat < 0) begin rd = rdata; rvat = k; end
      @(negedge clk);
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    int nc, cs, rv;
    repeat (3) @(negedge clk);
    chk(busy == 0 && rvalid == 0 && cost_vld == 0, "R11 reset outputs", {busy, rvalid, cost_vld}, 0);
    chk(sram_dirty == 0, "R6 dirty after reset", sram_dirty, 0);
    rst_n = 1;

    access(0, 0, 0, 24'h700000, 0, rd, nc, cs, rv);
    chk(nc == 1 && cs == 0, "R1 reset table cost zero", cs, 0);
    chk(rd == 16'h0000 && rv == 0, "R7 reset open bus", rd, 0);

    cfg(8'h00, 3'd0, 4'd2);
    cfg(8'h01, 3'd1, 4'd3);
    cfg(8'h20, 3'd3, 4'd6);
    cfg(8'h21, 3'd3, 4'd6);
    cfg(8'h22, 3'd3, 4'd6);
    cfg(8'h40, 3'd4, 4'd4);
    cfg(8'h70, 3'd2, 4'd8);
    cfg(8'h71, 3'd2, 4'd8);

    access(0, 0, 0, 24'h000123, 0, rd, nc, cs, rv);
    chk(rd == 16'h0000, "R7 unmapped byte read", rd, 0);
    chk(nc == 1 && cs == 2, "R1 loaded cost", cs, 2);

    access(1, 0, 0, 24'h700000, 16'h0022, rd, nc, cs, rv);
    chk(sram_dirty == 0, "R5 zero mask write dropped", sram_dirty, 0);
    access(1, 0, 0, 24'h406200, 16'h0066, rd, nc, cs, rv);
    chk(sram_dirty == 1, "R6 work write sets dirty", sram_dirty, 1);
    access(0, 0, 0, 24'h406200, 0, rd, nc, cs, rv);
    chk(rd == 16'h0066, "R4 work RAM ignores zero mask", rd, 16'h0066);

    setmask(14'h3FFF);
    access(1, 0, 0, 24'h700000, 16'h0011, rd, nc, cs, rv);
    setmask(14'h0000);
    access(1, 0, 0, 24'h700000, 16'h0099, rd, nc, cs, rv);
    setmask(14'h3FFF);
    access(0, 0, 0, 24'h700000, 0, rd, nc, cs, rv);
    chk(rd == 16'h0011, "R5 write under zero mask discarded", rd, 16'h0011);
    chk(sram_dirty == 1, "R6 dirty stays set", sram_dirty, 1);

    for (int v = 0; v < 14; v++) begin
      access(VEC[v][57], VEC[v][56], 0, VEC[v][55:32], VEC[v][31:16], rd, nc, cs, rv);
      if (!VEC[v][57])
        chk(rd == VEC[v][15:0], $sformatf("R2 R3 R4 R8 vector %0d", v), rd, VEC[v][15:0]);
    end

    access(0, 0, 0, 24'h700005, 0, rd, nc, cs, rv);
    chk(rd == 16'h00A5 && rv == 0, "R11 byte read latency", {rv[7:0], rd}, 16'h00A5);
    chk(nc == 1 && cs == 8, "R10 byte cost", cs, 8);
    access(0, 1, 0, 24'h000000, 0, rd, nc, cs, rv);
    chk(rd == 16'hA5A5 && rv == 1, "R7 unmapped wide replicated", rd, 16'hA5A5);
    chk(nc == 1 && cs == 4, "R10 wide cost doubled", cs, 4);

    access(0, 1, 0, 24'h700020, 0, rd, nc, cs, rv);
    chk(nc == 1 && cs == 16, "R10 wide save RAM cost", cs, 16);
    access(0, 0, 1, 24'h012100, 0, rd, nc, cs, rv);
    chk(nc == 1 && cs == 0, "R10 DMA on CPU registers free", cs, 0);
    chk(rd == 16'h00BE, "R7 CPU register block returns open bus", rd, 16'h00BE);
    access(0, 0, 0, 24'h012100, 0, rd, nc, cs, rv);
    chk(nc == 1 && cs == 3, "R10 CPU registers without DMA", cs, 3);

    access(1, 0, 0, 24'h703FFF, 16'h00C7, rd, nc, cs, rv);
    access(0, 0, 0, 24'h700005, 0, rd, nc, cs, rv);
    access(0, 1, 0, 24'h71FFFF, 0, rd, nc, cs, rv);
    chk(rd == 16'hC7C7, "R9 split into unmapped bank", rd, 16'hC7C7);
    chk(nc == 2 && cs == 8, "R9 split cost per beat", cs, 8);
    access(1, 1, 0, 24'h700FFF, 16'h2468, rd, nc, cs, rv);
    access(0, 1, 0, 24'h700FFF, 0, rd, nc, cs, rv);
    chk(rd == 16'h2468 && nc == 2 && cs == 16, "R9 split mapped wide read", rd, 16'h2468);
    access(0, 0, 0, 24'h701000, 0, rd, nc, cs, rv);
    chk(rd == 16'h0024, "R8 high byte at address plus one", rd, 16'h0024);

    setmask(14'h00FF);
    access(1, 1, 0, 24'h7000FF, 16'hABCD, rd, nc, cs, rv);
    setmask(14'h3FFF);
    access(0, 0, 0, 24'h700000, 0, rd, nc, cs, rv);
    chk(rd == 16'h00AB, "R8 high byte wraps under small mask", rd, 16'h00AB);
    access(0, 0, 0, 24'h7000FF, 0, rd, nc, cs, rv);
    chk(rd == 16'h00CD, "R8 low byte under small mask", rd, 16'h00CD);

    access(1, 0, 0, 24'h700040, 16'h0044, rd, nc, cs, rv);
    @(negedge clk);
    req = 1; req_we = 1; req_wide = 1; req_dma = 0; req_addr = 24'h700030; req_wdata = 16'h5566;
    @(negedge clk);
    chk(busy == 1, "R11 busy during high beat", busy, 1);
    req_wide = 0; req_addr = 24'h700040; req_wdata = 16'h0099;
    @(negedge clk);
    req = 0;
    chk(busy == 0, "R11 busy lasts one cycle", busy, 0);
    access(0, 0, 0, 24'h700040, 0, rd, nc, cs, rv);
    chk(rd == 16'h0044, "R11 request while busy ignored", rd, 16'h0044);
    access(0, 1, 0, 24'h700030, 0, rd, nc, cs, rv);
    chk(rd == 16'h5566 && rv == 1, "R11 wide read latency", rd, 16'h5566);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule